// File: doc/BRIEF.md
# Debug Link Clock Rate Controller

This block produces the bit-rate enable tick for a serial debug link. It derives the tick from a fixed system clock. Software or a host sequencer asks for a link frequency in Hz. The block works out the integer divider that gets closest to that frequency without exceeding it. It reports the frequency that divider really yields and then moves the tick generator to the new divider. Two sequential divides are used, one after the other: the first gives the divider from the request, the second gives the achieved frequency from the divider.

Frequency changes do not all take effect the same way. A change that slows the link down is committed at the next tick, whatever the link is doing. A change that speeds the link up stays pending while the transaction queue reports that it is still busy. This keeps work that was already queued at the pace it was issued at. A later request always replaces a pending one. A negative request changes nothing and only reads back the rate in force. Every divider change lands on a tick boundary, so the link clock never sees a short phase.

Top module: `dbgclk_rate`

## Requirements
- R1: After reset the divider is RESET_DIV (default 50), `rate_hz` reads SYS_HZ/(2*RESET_DIV) (1000000 at the default 100 MHz), `ack` is low, and ticks are RESET_DIV cycles apart.
- R2: For a request f > 0, the divider is N = ceil(SYS_HZ/(2f)), and the reported frequency is floor(SYS_HZ/(2N)), which is never above f when f is reachable.
- R3: N is clamped to 1..65535. A request of SYS_HZ/2 or more gives SYS_HZ/2. A request of zero, or one below the slowest rate, gives floor(SYS_HZ/131070) (762 at the default).
- R4: Each request taken while the block is idle produces a one-cycle `ack` pulse, with `ack_hz` holding the rounded frequency. The block is idle again in the cycle of the pulse. Requests that arrive while a computation is running are dropped.
- R5: A request with bit 31 set (negative) is acknowledged in the cycle after it is presented. `ack_hz` then equals the current `rate_hz`, and the rate and the tick spacing are left unchanged.
- R6: A result with a divider at least as large as the current one (same or slower) is committed at the next tick, even while `queue_busy` is high.
- R7: A result with a smaller divider (faster) is committed only at a tick in which `queue_busy` is low. `rate_hz` never rises while the queue is busy.
- R8: A newer result replaces any pending result. A pending faster rate that has been replaced never becomes the rate in force.
- R9: `rate_hz` and the divider change only on a tick. The tick period in progress always runs out at the old spacing before the new spacing starts.
- R10: `tick` is high for one cycle in every N system cycles, where N is the divider in force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_hz | input | 32 | Requested frequency in Hz, signed two's complement |
| queue_busy | input | 1 | High while queued link transactions are still executing |
| tick | output | 1 | Link bit-rate enable, one cycle per divider period |
| rate_hz | output | 32 | Frequency currently in force, in Hz |
| ack | output | 1 | One-cycle acknowledge of a request |
| ack_hz | output | 32 | Rounded frequency (or current rate for a query), valid with ack |

## Verification
The case that is hardest to reach from the ports is a faster rate that is stuck behind a busy queue and is then overtaken by another request. The stimulus holds `queue_busy` high, issues two faster requests one after the other, and checks that the rate has not moved. It then releases the queue and checks that only the second value is committed. A second sequence overtakes a pending faster rate with a slower one while the queue stays busy. Tick spacings are measured before and after a change, to show that the old period runs out in full.

// File: rtl/dbgclk_pkg.sv
package dbgclk_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DIVN = 2'd1,
        PH_DIVF = 2'd2
    } phase_e;

endpackage

// File: rtl/dbgclk_div.sv
module dbgclk_div #(
    parameter int unsigned W = 34
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int unsigned CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic             run;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [W:0]       rem;
        logic [W-1:0]     acc;
        logic [W-1:0]     den;
    } dv_t;

    dv_t s_d, s_q;

    logic [W:0] trial;
    logic       fits;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        trial    = {s_q.rem[W-1:0], s_q.acc[W-1]};
        fits     = s_q.rem[W] || (trial >= {1'b0, s_q.den});
        if (start) begin
            s_d.run = 1'b1;
            s_d.cnt = CNT_W'(W);
            s_d.rem = '0;
            s_d.acc = num;
            s_d.den = den;
        end else if (s_q.run) begin
            s_d.rem = fits ? (trial - {1'b0, s_q.den}) : trial;
            s_d.acc = {s_q.acc[W-2:0], fits};
            s_d.cnt = s_q.cnt - CNT_W'(1);
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.run  = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign done = s_q.done;
    assign quo  = s_q.acc;

endmodule

// File: rtl/dbgclk_tick.sv
module dbgclk_tick #(
    parameter int unsigned DIV_W     = 16,
    parameter int unsigned RESET_DIV = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] reload_n,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == '0);
        cnt_d = tick ? (reload_n - DIV_W'(1)) : (cnt_q - DIV_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= DIV_W'(RESET_DIV - 1);
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/dbgclk_rate.sv
module dbgclk_rate #(
    parameter int unsigned SYS_HZ    = 100_000_000,
    parameter int unsigned FREQ_W    = 32,
    parameter int unsigned DIV_W     = 16,
    parameter int unsigned RESET_DIV = 50
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic signed [FREQ_W-1:0] req_hz,
    input  logic                     queue_busy,
    output logic                     tick,
    output logic [FREQ_W-1:0]        rate_hz,
    output logic                     ack,
    output logic [FREQ_W-1:0]        ack_hz
);
    import dbgclk_pkg::*;

    localparam int unsigned NUM_W    = FREQ_W + 2;
    localparam int unsigned MAX_DIV  = (1 << DIV_W) - 1;
    localparam int unsigned RESET_HZ = SYS_HZ / (2 * RESET_DIV);

    typedef struct packed {
        phase_e            phase;
        logic [DIV_W-1:0]  new_n;
        logic [DIV_W-1:0]  cur_n;
        logic [FREQ_W-1:0] cur_hz;
        logic              pend_vld;
        logic [DIV_W-1:0]  pend_n;
        logic [FREQ_W-1:0] pend_hz;
        logic              ack;
        logic [FREQ_W-1:0] ack_hz;
    } ctl_t;

    ctl_t s_d, s_q;

    logic             div_start;
    logic [NUM_W-1:0] div_num;
    logic [NUM_W-1:0] div_den;
    logic             div_done;
    logic [NUM_W-1:0] div_quo;
    logic [DIV_W-1:0] tick_reload;
    logic             commit;
    logic [DIV_W-1:0] n_clamp;
    logic [NUM_W-1:0] req_twice;

    always_comb begin
        s_d         = s_q;
        s_d.ack     = 1'b0;
        div_start   = 1'b0;
        div_num     = '0;
        div_den     = '0;
        tick_reload = s_q.cur_n;
        req_twice   = NUM_W'($unsigned(req_hz)) << 1;

        if (div_quo > NUM_W'(MAX_DIV)) begin
            n_clamp = DIV_W'(MAX_DIV);
        end else if (div_quo == '0) begin
            n_clamp = DIV_W'(1);
        end else begin
            n_clamp = div_quo[DIV_W-1:0];
        end

        // slower or equal rates go at once; faster ones wait for an idle queue
        commit = tick && s_q.pend_vld &&
                 ((s_q.pend_n >= s_q.cur_n) || !queue_busy);
        if (commit) begin
            s_d.cur_n    = s_q.pend_n;
            s_d.cur_hz   = s_q.pend_hz;
            s_d.pend_vld = 1'b0;
            tick_reload  = s_q.pend_n;
        end

        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    if (req_hz[FREQ_W-1]) begin
                        s_d.ack    = 1'b1;
                        s_d.ack_hz = s_q.cur_hz;
                    end else if (req_hz == '0) begin
                        s_d.new_n = DIV_W'(MAX_DIV);
                        div_start = 1'b1;
                        div_num   = NUM_W'(SYS_HZ);
                        div_den   = NUM_W'(MAX_DIV) << 1;
                        s_d.phase = PH_DIVF;
                    end else begin
                        div_start = 1'b1;
                        div_num   = NUM_W'(SYS_HZ) + req_twice - NUM_W'(1);
                        div_den   = req_twice;
                        s_d.phase = PH_DIVN;
                    end
                end
            end
            PH_DIVN: begin
                if (div_done) begin
                    s_d.new_n = n_clamp;
                    div_start = 1'b1;
                    div_num   = NUM_W'(SYS_HZ);
                    div_den   = NUM_W'(n_clamp) << 1;
                    s_d.phase = PH_DIVF;
                end
            end
            PH_DIVF: begin
                if (div_done) begin
                    s_d.ack      = 1'b1;
                    s_d.ack_hz   = div_quo[FREQ_W-1:0];
                    s_d.pend_vld = 1'b1;
                    s_d.pend_n   = s_q.new_n;
                    s_d.pend_hz  = div_quo[FREQ_W-1:0];
                    s_d.phase    = PH_IDLE;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.phase    <= PH_IDLE;
            s_q.cur_n    <= DIV_W'(RESET_DIV);
            s_q.cur_hz   <= FREQ_W'(RESET_HZ);
        end else begin
            s_q <= s_d;
        end
    end

    dbgclk_div #(.W(NUM_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    dbgclk_tick #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_n (tick_reload),
        .tick     (tick)
    );

    assign rate_hz = s_q.cur_hz;
    assign ack     = s_q.ack;
    assign ack_hz  = s_q.ack_hz;

endmodule

// File: rtl/dbgclk_chk.sv
module dbgclk_chk #(
    parameter int unsigned SYS_HZ = 100_000_000,
    parameter int unsigned FREQ_W = 32,
    parameter int unsigned DIV_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              queue_busy,
    input logic              tick,
    input logic [FREQ_W-1:0] rate_hz,
    input logic              ack,
    input logic [FREQ_W-1:0] ack_hz
);
    localparam int unsigned F_MIN = SYS_HZ / (2 * ((1 << DIV_W) - 1));
    localparam int unsigned F_MAX = SYS_HZ / 2;

    // R9: the rate in force moves only on the edge that closes a tick
    a_r9_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_hz != $past(rate_hz)) |-> $past(tick));

    // R7: a faster rate is never committed while the queue is busy
    a_r7_faster_waits_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_hz > $past(rate_hz)) |-> !$past(queue_busy));

    // R3: the rate in force stays inside the reachable range
    a_r3_rate_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_hz >= FREQ_W'(F_MIN)) && (rate_hz <= FREQ_W'(F_MAX)));

    // R4: every acknowledged value is a reachable frequency
    a_r4_ack_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ((ack_hz >= FREQ_W'(F_MIN)) && (ack_hz <= FREQ_W'(F_MAX))));

endmodule

bind dbgclk_rate dbgclk_chk #(.SYS_HZ(SYS_HZ), .FREQ_W(FREQ_W), .DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .queue_busy (queue_busy),
    .tick       (tick),
    .rate_hz    (rate_hz),
    .ack        (ack),
    .ack_hz     (ack_hz)
);

// File: tb/dbgclk_rate_tb.sv
`timescale 1ns/1ps
module dbgclk_rate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic signed [31:0] req_hz = '0;
    logic        queue_busy = 1'b0;
    logic        tick;
    logic [31:0] rate_hz;
    logic        ack;
    logic [31:0] ack_hz;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_tick = 0;
    int last_gap = 0;
    int wait_cnt = 0;
    logic [31:0] got_hz;
    bit finished = 0;

    localparam int NV = 12;
    localparam int VEC_REQ [0:NV-1] = '{1_000_000, 3_000_000, 50_000_000, 2_000_000_000,
                                        0, 100, 763, 12_345_678, 7, 25_000_000,
                                        33_333_334, 16_666_667};
    localparam int VEC_EXP [0:NV-1] = '{1_000_000, 2_941_176, 50_000_000, 50_000_000,
                                        762, 762, 762, 10_000_000, 762, 25_000_000,
                                        25_000_000, 16_666_666};

    always #5 clk = ~clk;

    dbgclk_rate u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hz(req_hz),
        .queue_busy(queue_busy), .tick(tick), .rate_hz(rate_hz),
        .ack(ack), .ack_hz(ack_hz)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            cyc <= cyc + 1;
            if (tick) begin
                last_gap  <= cyc - last_tick;
                last_tick <= cyc;
            end
        end
    end

    task automatic check(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic request(input int hz);
        @(negedge clk);
        req_valid = 1'b1;
        req_hz    = hz;
        @(negedge clk);
        req_valid = 1'b0;
        wait_cnt  = 0;
        while (!ack && wait_cnt < 300) begin
            @(negedge clk);
            wait_cnt++;
        end
        got_hz = ack_hz;
        @(negedge clk);
        check("R4 ack is a single-cycle pulse", ack, 0);
    endtask

    task automatic wait_tick();
        @(negedge clk);
        while (!tick) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rate after reset", rate_hz, 1_000_000);
        check("R1 ack low after reset", ack, 0);
        wait_tick();
        wait_tick();
        check("R1 reset tick spacing", last_gap, 50);

        // R7: faster rate held while queue busy
        queue_busy = 1'b1;
        request(5_000_000);
        check("R2 ack for 5 MHz", got_hz, 5_000_000);
        repeat (200) @(negedge clk);
        check("R7 rate held while busy", rate_hz, 1_000_000);
        check("R10 spacing unchanged while busy", last_gap, 50);
        queue_busy = 1'b0;
        repeat (60) @(negedge clk);
        check("R7 rate after queue idle", rate_hz, 5_000_000);
        wait_tick();
        wait_tick();
        check("R10 tick spacing at 5 MHz", last_gap, 10);

        // R6: slower rate goes through despite busy
        queue_busy = 1'b1;
        request(1_000_000);
        repeat (15) @(negedge clk);
        check("R6 slower rate committed while busy", rate_hz, 1_000_000);

        // R8: replacement of a pending faster rate
        request(10_000_000);
        request(2_000_000);
        check("R8 second ack value", got_hz, 2_000_000);
        repeat (100) @(negedge clk);
        check("R8 nothing committed while busy", rate_hz, 1_000_000);
        queue_busy = 1'b0;
        repeat (60) @(negedge clk);
        check("R8 newest faster rate wins", rate_hz, 2_000_000);
        queue_busy = 1'b1;
        request(10_000_000);
        request(500_000);
        repeat (30) @(negedge clk);
        check("R8 slower overtakes pending faster", rate_hz, 500_000);
        queue_busy = 1'b0;
        repeat (200) @(negedge clk);
        check("R8 overtaken rate never applied", rate_hz, 500_000);

        // R9: old period completes before new spacing
        request(5_000_000);
        wait_tick();
        check("R9 old period runs out in full", last_gap, 100);
        wait_tick();
        check("R9 new spacing after boundary", last_gap, 10);

        // R5: negative request is a query
        @(negedge clk);
        req_valid = 1'b1;
        req_hz    = -1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R5 query ack next cycle", ack, 1);
        check("R5 query returns current rate", ack_hz, 5_000_000);
        repeat (40) @(negedge clk);
        check("R5 query leaves rate unchanged", rate_hz, 5_000_000);
        check("R5 query leaves spacing unchanged", last_gap, 10);

        // R2 / R3: rounding and clamping table
        for (int i = 0; i < NV; i++) begin
            request(VEC_REQ[i]);
            check($sformatf("R2/R3 vector %0d req=%0d", i, VEC_REQ[i]), got_hz, VEC_EXP[i]);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule